// File: doc/BRIEF.md
# Serial Slave Port with Edge-Selectable Frame Sync

This block is the receive and transmit side of a four-wire serial slave. The serial clock, the chip-select line and the data input are brought into the system clock domain through two-flop synchronisers. The system clock must run at least four times faster than the serial clock. Bits are sampled on the rising serial-clock edge, most significant bit first. Outgoing data changes after the falling edge. Each completed word goes into a small receive FIFO that software reads through a four-entry register window.

Chip-select is handled in one of three ways. In the gated way it frames the transfer, so clocks seen while it is high count for nothing. In the two sync ways a single edge, either falling or rising, starts one word, and the line's level after that no longer matters. If a sync edge arrives in the middle of a word, the bits taken so far are stored as a short word, a break flag is raised and a fresh word begins. For each outgoing word the slave uses the word software queued, or the default-word register when nothing is queued. A one-cycle interrupt pulse reports completed words, or only FIFO-full, break and end-of-select events, as configured.

Top module: `spi_fsync_slave`

## Requirements
- R1: Register 0 holds the configuration. Bits [3:0] give the word length minus one. Bits [5:4] select chip-select handling: 00 gated, 10 falling-edge sync, 11 rising-edge sync, and 01 behaves as gated. Bit 6 selects the interrupt policy. Bit 7 is the soft reset, which always reads 0. All state is 0 after the reset input.
- R2: In gated handling, serial-clock edges while chip-select is high have no effect. A word starts when chip-select falls, and further words follow back to back while it stays low.
- R3: In gated handling, raising chip-select before a word is complete discards the partial word and raises no interrupt.
- R4: In falling-edge handling, a falling chip-select edge starts one word. Raising chip-select does not abort it. Once the word is complete, clock edges are ignored until the next sync edge.
- R5: In either sync handling, a sync edge that arrives after at least one bit of a word stores the partial bits, right-aligned, as a word. It also sets break status bit 1, pulses the interrupt and starts a new word.
- R6: Rising-edge handling behaves like falling-edge handling, but the word is started by the rising chip-select edge.
- R7: A word holds length-field+1 bits, from 1 to 16. Data is shifted MSB first in both directions, and received words are right-aligned.
- R8: With interrupt policy 0, the interrupt pulses for one cycle for every completed word.
- R9: With interrupt policy 1, the interrupt pulses only when the FIFO becomes full, on a break, or when chip-select rises while the FIFO holds data.
- R10: Writing register 2 queues a transmit word and sets status bit 2. Each word start takes the queued word and clears bit 2; if no word is queued, the word start takes register 3, the default word.
- R11: The receive FIFO holds 4 words. Reading register 2 returns the oldest word and removes it. A word that completes while the FIFO is full is dropped.
- R12: Status register 1 reports data available in bit 0, break in bit 1, transmit word queued in bit 2, FIFO full in bit 3 and FIFO count in bits [6:4]. Writing 1 to bit 1 clears the break flag.
- R13: A write to register 0 with bit 7 set empties the FIFO and clears the shifter, the break flag and the queued transmit word. The other fields take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Chip-select / frame sync, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops FIFO at register 2) |
| addr | input | 2 | Register select |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A bit counter out of step with the frame shows up at once in the next word read from the FIFO: it comes out shifted, or split where it should be whole. Tests that carry no mismatch of their own always send a single word of known length right after the suspect event, so a leftover bit or a lost bit shows up within one word. Errors in the interrupt policy show up as a count of pulses that differs from the model's after each scenario. Errors in the transmit choice show up in the bits captured from miso during the very next word.

// File: rtl/spi_fsync_slave.sv
module spi_fsync_slave #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int LW = $clog2(DW);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [2:0]    sck_q, cs_q;
  logic [1:0]    din_q;
  logic [LW-1:0] cfg_len, bitcnt;
  logic [1:0]    cfg_mode;
  logic          cfg_fmode, active, brk, tx_full;
  logic [DW-1:0] rx_sh, tx_sh, tx_hold, dflt;
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0; cs_q <= '1; din_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      cs_q  <= {cs_q[1:0], cs_n};
      din_q <= {din_q[0], mosi};
    end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_fall  = ~cs_q[1] & cs_q[2];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire sync_md  = cfg_mode[1];
  wire start    = sync_md ? (cfg_mode[0] ? cs_rise : cs_fall) : cs_fall;
  wire wr_cfg   = wr_en && addr == 2'd0;
  wire srst     = wr_cfg && wdata[7];
  wire full     = cnt == CW'(DEPTH);

  wire [DW-1:0] rx_bit   = {rx_sh[DW-2:0], din_q[1]};
  wire          done     = active && sck_rise && !start && bitcnt == cfg_len;
  wire          brk_ev   = sync_md && start && active && bitcnt != '0;
  wire          push     = done || brk_ev;
  wire          push_ok  = push && !full;
  wire [DW-1:0] push_w   = brk_ev ? rx_sh : rx_bit;
  wire          pop      = rd_en && addr == 2'd2 && cnt != '0;
  wire          load     = start || (done && !sync_md);
  wire [DW-1:0] tx_next  = tx_full ? tx_hold : dflt;
  wire          irq_ev   = brk_ev || (push && (!cfg_fmode || (push_ok && cnt == CW'(DEPTH - 1))))
                          || (cfg_fmode && cs_rise && cnt != '0);

  assign miso = tx_sh[cfg_len];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_len <= '0; cfg_mode <= '0; cfg_fmode <= 1'b0; dflt <= '0; tx_hold <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_len <= wdata[LW-1:0]; cfg_mode <= wdata[5:4]; cfg_fmode <= wdata[6];
      end
      if (wr_en && addr == 2'd3) dflt <= wdata;
      if (wr_en && addr == 2'd2) tx_hold <= wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; bitcnt <= '0; rx_sh <= '0; tx_sh <= '0; tx_full <= 1'b0;
      brk <= 1'b0; wp <= '0; rp <= '0; cnt <= '0; irq <= 1'b0;
    end else if (srst) begin
      active <= 1'b0; bitcnt <= '0; rx_sh <= '0; tx_sh <= '0; tx_full <= 1'b0;
      brk <= 1'b0; wp <= '0; rp <= '0; cnt <= '0; irq <= 1'b0;
    end else begin
      if (start) begin
        active <= 1'b1; bitcnt <= '0; rx_sh <= '0;
      end else if (!sync_md && cs_q[1]) begin
        active <= 1'b0; bitcnt <= '0;
      end else if (active && sck_rise) begin
        if (done) begin
          bitcnt <= '0; rx_sh <= '0;
          if (sync_md) active <= 1'b0;
        end else begin
          bitcnt <= bitcnt + 1'b1; rx_sh <= rx_bit;
        end
      end
      if (load) tx_sh <= tx_next;
      else if (active && sck_fall && bitcnt != '0) tx_sh <= tx_sh << 1;
      if (wr_en && addr == 2'd2) tx_full <= 1'b1;
      else if (load) tx_full <= 1'b0;
      if (brk_ev) brk <= 1'b1;
      else if (wr_en && addr == 2'd1 && wdata[1]) brk <= 1'b0;
      if (push_ok) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)     rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push_ok) - CW'(pop);
      irq <= irq_ev;
    end

  always_ff @(posedge clk)
    if (push_ok && !srst) mem[wp] <= push_w;

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: begin rdata[LW-1:0] = cfg_len; rdata[5:4] = cfg_mode; rdata[6] = cfg_fmode; end
      2'd1: begin
        rdata[0] = cnt != '0; rdata[1] = brk; rdata[2] = tx_full; rdata[3] = full;
        rdata[4 +: CW] = cnt;
      end
      2'd2: rdata = (cnt != '0) ? mem[rp] : '0;
      default: rdata = dflt;
    endcase
  end

  // R11
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));

  // R11
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !srst) |=> cnt == CW'(DEPTH));

  // R5
  break_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(brk) |-> irq);

  // R5
  break_sync_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk) |-> $past(cfg_mode[1]));

  // R8
  word_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fmode && cnt > $past(cnt)) |-> irq);
endmodule

// File: tb/spi_fsync_slave_tb.sv
module spi_fsync_slave_tb;
  localparam int H = 8;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0;
  logic miso, irq;
  logic [15:0] rdata;
  int checks = 0, errors = 0, irq_seen = 0, exp_irq = 0;
  logic [15:0] exp_q[$];
  logic [15:0] mi, rd;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_fsync_slave u_dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always @(negedge clk) if (rst_n && irq) irq_seen++;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rdr(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic cs(input logic v);
    cs_n = v; repeat (H) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [15:0] mo, output logic [15:0] got);
    got = 0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = mo[i];
      repeat (H) @(negedge clk);
      got[i] = miso;
      sclk = 1;
      repeat (H) @(negedge clk);
      sclk = 0;
    end
    repeat (H) @(negedge clk);
  endtask

  task automatic word(input int n, input logic [15:0] mo);
    logic [15:0] g;
    xfer(n, mo, g);
  endtask

  task automatic drain(input string tag);
    logic [15:0] d;
    while (exp_q.size() > 0) begin
      rdr(2'd2, d);
      check(tag, d, exp_q.pop_front());
    end
    rdr(2'd1, d);
    check({tag, " empty"}, d & 16'h0079, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rdr(2'd1, rd); check("R1 status after reset", rd, 16'h0000);
    rdr(2'd0, rd); check("R1 config after reset", rd, 16'h0000);
    check("R1 miso after reset", {15'd0, miso}, 16'd0);

    // R10 R7 gated, queued word then default word
    wr(2'd0, 16'h0007); wr(2'd3, 16'h005A); wr(2'd2, 16'h00A5);
    rdr(2'd1, rd); check("R10 tx queued flag", rd, 16'h0004);
    cs(0);
    xfer(8, 16'h003C, mi); check("R10 queued word out", mi, 16'h00A5);
    xfer(8, 16'h00C3, mi); check("R10 default word out", mi, 16'h005A);
    cs(1);
    exp_q.push_back(16'h003C); exp_q.push_back(16'h00C3); exp_irq += 2;
    check("R8 irq per word", irq_seen[15:0], exp_irq[15:0]);
    drain("R2 back-to-back words");

    // R2 R3 ignored clocks with cs high, abort mid-word
    word(5, 16'h001F);
    rdr(2'd1, rd); check("R2 clocks ignored while deselected", rd, 16'h0000);
    cs(0); word(3, 16'h0005); cs(1);
    rdr(2'd1, rd); check("R3 abort stores nothing", rd, 16'h0000);
    check("R3 abort no irq", irq_seen[15:0], exp_irq[15:0]);
    cs(0); word(8, 16'h0096); cs(1);
    exp_q.push_back(16'h0096); exp_irq++;
    drain("R3 clean word after abort");

    // R4 falling-edge sync
    wr(2'd0, 16'h0027);
    cs(0); word(3, 16'h0006); cs(1); word(5, 16'h000B);
    word(2, 16'h0003);
    cs(0); word(8, 16'h0044); cs(1);
    exp_q.push_back(16'h00CB); exp_q.push_back(16'h0044); exp_irq += 2;
    check("R4 irq count", irq_seen[15:0], exp_irq[15:0]);
    drain("R4 word survives deselect");

    // R5 break in falling mode
    cs(0); word(3, 16'h0005); cs(1); cs(0); word(8, 16'h0081); cs(1);
    exp_q.push_back(16'h0005); exp_q.push_back(16'h0081); exp_irq += 2;
    rdr(2'd1, rd); check("R5 break flag set", rd & 16'h0002, 16'h0002);
    check("R5 break irq", irq_seen[15:0], exp_irq[15:0]);
    drain("R5 partial word then fresh word");
    wr(2'd1, 16'h0002);
    rdr(2'd1, rd); check("R12 break cleared", rd, 16'h0000);

    // R6 rising-edge sync
    wr(2'd0, 16'h0037);
    cs(0); cs(1);
    xfer(8, 16'h006E, mi); check("R6 default word out", mi, 16'h005A);
    cs(0);
    cs(1); word(2, 16'h0003); cs(0); cs(1); word(8, 16'h0012);
    exp_q.push_back(16'h006E); exp_q.push_back(16'h0003); exp_q.push_back(16'h0012); exp_irq += 3;
    check("R6 irq count", irq_seen[15:0], exp_irq[15:0]);
    drain("R6 rising sync words");
    wr(2'd1, 16'h0002);

    // R7 lengths 16 and 1
    wr(2'd0, 16'h000F); wr(2'd2, 16'hBEEF);
    cs(0); xfer(16, 16'h1234, mi); cs(1);
    check("R7 16-bit word out", mi, 16'hBEEF);
    wr(2'd0, 16'h0000);
    cs(0); word(3, 16'h0005); cs(1);
    exp_q.push_back(16'h1234); exp_q.push_back(16'h0001); exp_q.push_back(16'h0000);
    exp_q.push_back(16'h0001); exp_irq += 4;
    check("R7 irq count", irq_seen[15:0], exp_irq[15:0]);
    drain("R7 word lengths");

    // R9 interrupt policy 1
    wr(2'd0, 16'h0047);
    cs(0); word(8, 16'h0011); word(8, 16'h0022); word(8, 16'h0033);
    check("R9 no irq before full", irq_seen[15:0], exp_irq[15:0]);
    word(8, 16'h0044); exp_irq++;
    check("R9 irq on full", irq_seen[15:0], exp_irq[15:0]);
    cs(1); exp_irq++;
    check("R9 irq on deselect with data", irq_seen[15:0], exp_irq[15:0]);
    exp_q.push_back(16'h0011); exp_q.push_back(16'h0022); exp_q.push_back(16'h0033);
    exp_q.push_back(16'h0044);
    drain("R9 fifo contents");
    cs(0); word(8, 16'h0055);
    check("R9 single word no irq", irq_seen[15:0], exp_irq[15:0]);
    cs(1); exp_irq++;
    check("R9 deselect irq", irq_seen[15:0], exp_irq[15:0]);
    exp_q.push_back(16'h0055);
    drain("R9 single word");

    // R11 overflow
    wr(2'd0, 16'h0007);
    cs(0);
    for (int k = 1; k <= 5; k++) word(8, 16'(k));
    cs(1);
    exp_irq += 5;
    for (int k = 1; k <= 4; k++) exp_q.push_back(16'(k));
    rdr(2'd1, rd); check("R12 full status", rd, 16'h0049);
    check("R11 irq count", irq_seen[15:0], exp_irq[15:0]);
    drain("R11 overflow drops newest");

    // R13 soft reset
    wr(2'd0, 16'h0027); wr(2'd2, 16'h1111);
    cs(0); word(8, 16'h0077); cs(1); cs(0); word(3, 16'h0005); cs(1); cs(0);
    word(2, 16'h0001);
    exp_irq += 2;
    wr(2'd0, 16'h00A7);
    rdr(2'd1, rd); check("R13 status cleared", rd, 16'h0000);
    rdr(2'd0, rd); check("R13 config kept", rd, 16'h0027);
    cs(1); cs(0); word(8, 16'h003A); cs(1);
    exp_q.push_back(16'h003A); exp_irq++;
    drain("R13 clean word after soft reset");
    check("R8 total irq", irq_seen[15:0], exp_irq[15:0]);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule